// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable, cycle-level model of a synchronous burst SRAM. The default size is 256 words of 36 bits, arranged as four 9-bit byte lanes. The rising clock edge samples every control and data input: the address, the write data, three chip selects, two address strobes, the burst advance and the write controls. An address loaded by either strobe can be followed by internally generated burst addresses. These come from a 2-bit counter that steps in linear or interleaved order and stays inside the aligned group of four words.

Read data leaves through a data output with a drive-enable flag that stands in for a tri-state pin. The value is zero whenever the data is not driven. A mode input picks one of two read paths. In the flow-through path, data comes combinationally from the captured address. In the pipelined path, data passes through an output register first. A captured deselect or write stops the drive straight after its edge. The output enable and the sleep input act without waiting for a clock edge. The stored contents survive sleep.

Top module: `burst_sram`

## Requirements
- R1: The chip counts as selected only when `ceLowA`=0, `ceHigh`=1 and `ceLowB`=0. If a strobe is sampled while the chip is not selected, the cycle is a deselect: nothing is written and the burst session ends.
- R2: A selected cycle with `procStrobeN`=0 loads `addrIn` and performs a read, even when the write controls are active.
- R3: A selected cycle with `ctrlStrobeN`=0 and `procStrobeN`=1 loads `addrIn`. It writes if global write or byte-write-enable with at least one lane is requested; otherwise it reads.
- R4: During a session, a cycle with no strobe and `advanceN`=0 steps a 2-bit count. Address bits [AW-1:2] stay unchanged. The low bits are (base+n) mod 4 when `linearOrder`=1 and base XOR n when `linearOrder`=0, where base is the loaded low 2 bits. Such a cycle writes if a write is requested and reads otherwise.
- R5: During a session, a cycle with no strobe and `advanceN`=1 reuses the current address.
- R6: Lane i is data bits [9i+8:9i]. With `byteWrEnN`=0, only lanes whose `laneWrN[i]`=0 are written. With `allWrN`=0, all four lanes are written, whatever the lane and byte-enable inputs are.
- R7: With `pipeMode`=0, a read's word appears on `dataOut`, with `dataDrive`=1, right after the edge that captures the command.
- R8: With `pipeMode`=1, a read's word appears one edge later than in R7.
- R9: `dataDrive` is 0 right after the edge that captures a deselect or a write, in both modes.
- R10: `outEnN`=1 forces `dataDrive`=0 and `dataOut`=0 at once, with no clock edge needed.
- R11: `sleepIn`=1 at two consecutive edges enters sleep. While asleep, the outputs are not driven and commands are ignored. Lowering `sleepIn` leaves sleep at once. Stored words are kept.
- R12: After reset, `dataDrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addrIn | input | ADDR_W | Word address loaded by a strobe |
| dataIn | input | LANES*LANE_W | Write data |
| ceLowA | input | 1 | Chip select, active low |
| ceHigh | input | 1 | Chip select, active high |
| ceLowB | input | 1 | Chip select, active low |
| procStrobeN | input | 1 | Read-start address strobe, active low, has priority |
| ctrlStrobeN | input | 1 | Read/write-start address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| laneWrN | input | LANES | Per-lane write select, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| allWrN | input | 1 | Global write of all lanes, active low |
| linearOrder | input | 1 | 1 linear burst order, 0 interleaved |
| pipeMode | input | 1 | 1 pipelined read path, 0 flow-through |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepIn | input | 1 | Sleep request, active high |
| dataOut | output | LANES*LANE_W | Read data, zero when not driven |
| dataDrive | output | 1 | High while dataOut is driven |

## Verification
On every clock, the assertions check the following. A deselect ends the session. A read-start strobe always yields a read of the sampled address. A held burst keeps its address. A burst step never leaves its 4-word group. The output enable and sleep always silence the outputs. Pipelined drive always follows a read from the cycle before. Only the bench's scenarios show the data itself: the latency of each read path, the order of the burst addresses, the merging of byte lanes, and that writes are dropped during sleep or deselect. The bench checks these against its own shadow of the memory, across full address sweeps and every lane mask.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_DESEL, OP_READ, OP_WRITE} op_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic wrStrobe;  // write this edge
    logic rdLive;    // read captured at last edge
    logic selLive;   // burst session open
    logic wrLive;    // write captured at last edge
    logic asleep;    // sleep state (partly asynchronous)
  } strobes_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceLowA,
  input  logic              ceHigh,
  input  logic              ceLowB,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              byteWrEnN,
  input  logic              allWrN,
  input  logic              linearOrder,
  input  logic              sleepIn,
  output strobes_t          strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrMask,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] curAddr, effAddr;
  logic [1:0]        baseLo, cnt, cntNext;
  logic              rdLive, wrLive, selLive, sleepQ1, sleepQ2;
  logic              sel, procAct, ctrlAct, wrReq, loadNew, step, asleep;
  logic [LANES-1:0]  reqMask;
  op_e               op;

  function automatic logic [1:0] orderLo(input logic [1:0] b, input logic [1:0] c,
                                         input logic lin);
    return lin ? 2'(b + c) : (b ^ c);
  endfunction

  assign sel     = !ceLowA && ceHigh && !ceLowB;
  assign procAct = !procStrobeN;
  assign ctrlAct = !ctrlStrobeN;
  assign reqMask = !allWrN ? '1 : (!byteWrEnN ? ~laneWrN : '0);
  assign wrReq   = |reqMask;
  assign asleep  = sleepIn && sleepQ2;
  assign cntNext = cnt + 2'd1;

  always_comb begin
    op      = OP_IDLE;
    loadNew = 1'b0;
    step    = 1'b0;
    if (asleep) begin
      op = OP_IDLE;
    end else if ((procAct || ctrlAct) && !sel) begin
      op = OP_DESEL;
    end else if (procAct) begin
      op      = OP_READ;
      loadNew = 1'b1;
    end else if (ctrlAct) begin
      op      = wrReq ? OP_WRITE : OP_READ;
      loadNew = 1'b1;
    end else if (selLive) begin
      op   = wrReq ? OP_WRITE : OP_READ;
      step = !advanceN;
    end
  end

  always_comb begin
    if (loadNew)   effAddr = addrIn;
    else if (step) effAddr = {curAddr[ADDR_W-1 -: HI_W], orderLo(baseLo, cntNext, linearOrder)};
    else           effAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr <= '0;
      baseLo  <= '0;
      cnt     <= '0;
      rdLive  <= 1'b0;
      wrLive  <= 1'b0;
      selLive <= 1'b0;
      sleepQ1 <= 1'b0;
      sleepQ2 <= 1'b0;
    end else begin
      sleepQ1 <= sleepIn;
      sleepQ2 <= sleepQ1;
      curAddr <= effAddr;
      if (loadNew) begin
        baseLo <= addrIn[1:0];
        cnt    <= '0;
      end else if (step) begin
        cnt <= cntNext;
      end
      selLive <= (op == OP_READ) || (op == OP_WRITE);
      rdLive  <= (op == OP_READ);
      wrLive  <= (op == OP_WRITE);
    end
  end

  assign strb.wrStrobe = (op == OP_WRITE);
  assign strb.rdLive   = rdLive;
  assign strb.selLive  = selLive;
  assign strb.wrLive   = wrLive;
  assign strb.asleep   = asleep;
  assign wrAddr        = effAddr;
  assign wrMask        = reqMask;
  assign rdAddr        = curAddr;

  p_desel_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && (procAct || ctrlAct) && !sel) |=> (!selLive && !rdLive));

  p_proc_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && procAct && sel) |=> (rdLive && rdAddr == $past(addrIn)));

  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && selLive && !procAct && !ctrlAct && advanceN) |=> $stable(rdAddr));

  p_group_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && selLive && !procAct && !ctrlAct && !advanceN)
      |=> (rdAddr[ADDR_W-1:2] == $past(rdAddr[ADDR_W-1:2])));
endmodule

// File: rtl/burst_sram_dpath.sv
module burst_sram_dpath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobes_t                strb,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrMask,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    pipeMode,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] flowData, outReg;
  logic              rdPipe, pipeOn, driveRaw;

  always_ff @(posedge clk) begin
    if (strb.wrStrobe) begin
      for (int i = 0; i < LANES; i++) begin
        if (wrMask[i]) mem[wrAddr][i*LANE_W +: LANE_W] <= dataIn[i*LANE_W +: LANE_W];
      end
    end
  end

  assign flowData = mem[rdAddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPipe <= 1'b0;
      outReg <= '0;
    end else begin
      rdPipe <= strb.rdLive;
      if (strb.rdLive) outReg <= flowData;
    end
  end

  // a captured deselect or write silences the pipelined output at once
  assign pipeOn    = rdPipe && strb.selLive && !strb.wrLive;
  assign driveRaw  = pipeMode ? pipeOn : strb.rdLive;
  assign dataDrive = driveRaw && !outEnN && !strb.asleep;
  assign dataOut   = dataDrive ? (pipeMode ? outReg : flowData) : '0;

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> (!dataDrive && dataOut == '0));

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strb.asleep |-> !dataDrive);

  p_pipe_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pipeMode && dataDrive) |-> $past(strb.rdLive));
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    ceLowA,
  input  logic                    ceHigh,
  input  logic                    ceLowB,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advanceN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    byteWrEnN,
  input  logic                    allWrN,
  input  logic                    linearOrder,
  input  logic                    pipeMode,
  input  logic                    outEnN,
  input  logic                    sleepIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);
  strobes_t          strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [LANES-1:0]  wrMask;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn),
    .ceLowA(ceLowA), .ceHigh(ceHigh), .ceLowB(ceLowB),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .laneWrN(laneWrN), .byteWrEnN(byteWrEnN), .allWrN(allWrN),
    .linearOrder(linearOrder), .sleepIn(sleepIn),
    .strb(strb), .wrAddr(wrAddr), .wrMask(wrMask), .rdAddr(rdAddr)
  );

  burst_sram_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrAddr(wrAddr), .wrMask(wrMask),
    .rdAddr(rdAddr), .dataIn(dataIn), .pipeMode(pipeMode), .outEnN(outEnN),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int W  = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addrIn;
  logic [W-1:0]  dataIn, dataOut;
  logic ceLowA, ceHigh, ceLowB, procStrobeN, ctrlStrobeN, advanceN;
  logic [NB-1:0] laneWrN;
  logic byteWrEnN, allWrN, linearOrder, pipeMode, outEnN, sleepIn, dataDrive;

  logic [W-1:0] refMem [DEPTH];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NB), .LANE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .dataIn(dataIn),
    .ceLowA(ceLowA), .ceHigh(ceHigh), .ceLowB(ceLowB),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .laneWrN(laneWrN), .byteWrEnN(byteWrEnN), .allWrN(allWrN),
    .linearOrder(linearOrder), .pipeMode(pipeMode), .outEnN(outEnN),
    .sleepIn(sleepIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic logic [W-1:0] pat(input int a, input int salt);
    logic [31:0] m;
    m = (32'(a) * 32'h9E3779B1) ^ 32'(salt * 7919);
    return {4'(a + salt), m};
  endfunction

  task automatic chkWord(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idleIn();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    laneWrN = '1; byteWrEnN = 1'b1; allWrN = 1'b1;
    ceLowA = 1'b0; ceHigh = 1'b1; ceLowB = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // flow-through read of one address, checked right after its edge
  task automatic flowRead(input int a, input string req);
    idleIn();
    addrIn = AW'(a); procStrobeN = 1'b0;
    tick();
    chkWord(req, dataOut, refMem[a]);
    idleIn();
  endtask

  task automatic fullWrite(input int a, input logic [W-1:0] d);
    idleIn();
    addrIn = AW'(a); dataIn = d; ctrlStrobeN = 1'b0; allWrN = 1'b0;
    tick();
    refMem[a] = d;
    idleIn();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] st;
    logic [1:0] lo;
    int lastA;
    rst_n = 1'b0; addrIn = '0; dataIn = '0; idleIn();
    linearOrder = 1'b1; pipeMode = 1'b0; outEnN = 1'b0; sleepIn = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chkBit("R12 reset drive", dataDrive, 1'b0);
    rst_n = 1'b1;
    tick();

    // R3: fill every word with global writes, drive silent during write
    for (int a = 0; a < DEPTH; a++) begin
      fullWrite(a, pat(a, 1));
      if (a == 5) chkBit("R9 write drive off", dataDrive, 1'b0);
    end

    // R7, R2: flow-through sweep; write controls active with the read strobe are ignored
    for (int a = 0; a < DEPTH; a++) begin
      idleIn();
      addrIn = AW'(a); procStrobeN = 1'b0; dataIn = ~pat(a, 1);
      allWrN = a[0] ? 1'b0 : 1'b1;
      tick();
      chkWord("R7 flow read", dataOut, refMem[a]);
      chkBit("R7 flow drive", dataDrive, 1'b1);
    end
    idleIn();
    flowRead(3, "R2 strobe write ignored");

    // R8: pipelined sweep, data one edge later
    pipeMode = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      idleIn();
      addrIn = AW'(a); procStrobeN = 1'b0;
      tick();
      if (a > 0) chkWord("R8 pipe read", dataOut, refMem[a-1]);
    end
    idleIn();
    tick();
    chkWord("R8 pipe last", dataOut, refMem[DEPTH-1]);
    pipeMode = 1'b0;

    // R4, R5: burst orders from every low-bit start, with wrap and hold
    for (int ord = 0; ord < 2; ord++) begin
      linearOrder = ord[0];
      for (int k = 0; k < 8; k++) begin
        st = AW'((k * 37 + 1) % DEPTH);
        flowRead(int'(st), "R4 burst start");
        lo = st[1:0];
        for (int n = 1; n <= 5; n++) begin
          idleIn(); advanceN = 1'b0;
          lo = linearOrder ? 2'(st[1:0] + 2'(n)) : (st[1:0] ^ 2'(n));
          tick();
          chkWord("R4 burst beat", dataOut, refMem[{st[AW-1:2], lo}]);
        end
        idleIn();
        tick();
        chkWord("R5 burst hold", dataOut, refMem[{st[AW-1:2], lo}]);
      end
    end
    linearOrder = 1'b1;

    // R6: every lane mask with byte-write enable
    for (int m = 0; m < 16; m++) begin
      idleIn();
      addrIn = AW'(100 + m); dataIn = pat(m, 7); ctrlStrobeN = 1'b0;
      byteWrEnN = 1'b0; laneWrN = ~4'(m);
      tick();
      for (int i = 0; i < NB; i++)
        if (m[i]) refMem[100 + m][i*BW +: BW] = pat(m, 7) >> (i*BW);
    end
    // R6: global write overrides lane and enable inputs
    idleIn();
    addrIn = AW'(120); dataIn = pat(120, 9); ctrlStrobeN = 1'b0;
    allWrN = 1'b0; byteWrEnN = 1'b1; laneWrN = '1;
    tick();
    refMem[120] = pat(120, 9);
    idleIn();
    addrIn = AW'(121); dataIn = pat(121, 9); ctrlStrobeN = 1'b0;
    allWrN = 1'b0; byteWrEnN = 1'b0; laneWrN = 4'b1110;
    tick();
    refMem[121] = pat(121, 9);
    for (int a = 100; a < 122; a++) flowRead(a, "R6 lane merge");

    // R3, R4: write burst in interleaved order from 202
    linearOrder = 1'b0;
    fullWrite(202, pat(0, 11));
    for (int n = 1; n < 4; n++) begin
      idleIn(); advanceN = 1'b0; allWrN = 1'b0; dataIn = pat(n, 11);
      tick();
      refMem[200 + ((2 ^ n) & 3)] = pat(n, 11);
    end
    idleIn();
    linearOrder = 1'b1;
    for (int a = 200; a < 204; a++) flowRead(a, "R4 write burst");

    // R1, R9: deselect in flow mode, write under deselect ignored
    flowRead(10, "R1 pre-deselect");
    ceHigh = 1'b0; procStrobeN = 1'b0;
    tick();
    chkBit("R9 flow deselect drive", dataDrive, 1'b0);
    chkWord("R9 flow deselect data", dataOut, '0);
    idleIn();
    addrIn = AW'(10); dataIn = pat(10, 99); ctrlStrobeN = 1'b0; allWrN = 1'b0; ceLowA = 1'b1;
    tick();
    chkBit("R1 deselect no drive", dataDrive, 1'b0);
    idleIn();
    addrIn = AW'(10); dataIn = pat(10, 98); ctrlStrobeN = 1'b0; allWrN = 1'b0; ceLowB = 1'b1;
    tick();
    idleIn();
    tick();
    chkBit("R1 session ended", dataDrive, 1'b0);
    flowRead(10, "R1 deselect write ignored");

    // R9: pipelined deselect and write cut the pending data
    pipeMode = 1'b1;
    idleIn(); addrIn = AW'(11); procStrobeN = 1'b0;
    tick();
    idleIn(); ceLowA = 1'b1; procStrobeN = 1'b0;
    tick();
    chkBit("R9 pipe deselect drive", dataDrive, 1'b0);
    idleIn(); addrIn = AW'(12); procStrobeN = 1'b0;
    tick();
    fullWrite(13, pat(13, 5));
    chkBit("R9 pipe write drive", dataDrive, 1'b0);
    idleIn(); addrIn = AW'(13); procStrobeN = 1'b0;
    tick();
    idleIn();
    tick();
    chkWord("R8 pipe after write", dataOut, refMem[13]);
    pipeMode = 1'b0;

    // R10: asynchronous output enable
    flowRead(20, "R10 pre");
    outEnN = 1'b1; #1;
    chkBit("R10 oe drive", dataDrive, 1'b0);
    chkWord("R10 oe data", dataOut, '0);
    outEnN = 1'b0; #1;
    chkWord("R10 oe restore", dataOut, refMem[20]);

    // R11: sleep after two edges, writes dropped, contents kept
    idleIn(); sleepIn = 1'b1;
    tick();
    tick();
    chkBit("R11 asleep drive", dataDrive, 1'b0);
    addrIn = AW'(30); dataIn = pat(30, 77); ctrlStrobeN = 1'b0; allWrN = 1'b0;
    tick();
    chkBit("R11 asleep write drive", dataDrive, 1'b0);
    idleIn();
    sleepIn = 1'b0;
    flowRead(30, "R11 retained");
    lastA = 255;
    flowRead(lastA, "R11 retained top");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule